// File: doc/BRIEF.md
# Bus Master Port Halt Sequencer

This block quiets a set of bus master ports before their subsystem is put back into reset. Each port has three wires. The block drives a halt request to the port. The port returns a halt acknowledge and an idle indication. A single command pulse starts a pass over all ports. The ports are handled one at a time, in ascending index order.

For each port the block first looks at the idle indication. If the port is already quiet, the block moves on without asking it anything. Otherwise it raises the halt request and waits for an acknowledge, or for a bounded number of millisecond ticks. It then grades the port on the idle indication alone, and lowers the request whatever the outcome. The port itself stays halted until the subsystem reset.

When the last port has been handled, a one-cycle done pulse is issued. A failure bit for each port holds the result until the next command is accepted. The acknowledge and idle inputs come from another clock domain, so each passes through a two-flop synchronizer before the sequencer uses it.

Top module: `axi_halt_seq`

## Requirements
- R1: While reset is applied and after it is released, with no command given, halt_req, halt_done and halt_fail are all zero.
- R2: A port whose synchronized idle bit is 1 when its turn comes never sees halt_req raised, and its halt_fail bit ends at 0.
- R3: For a port that is not idle, halt_req stays high until the synchronized acknowledge is 1, or until TIMEOUT_MS pulses of ms_tick have been counted. The request is never held for more than TIMEOUT_MS+2 ticks.
- R4: Ports are visited in ascending index order. At most one bit of halt_req is high at any time, and each port is requested at most once per command.
- R5: After the wait, halt_fail[p] is set to the inverse of the synchronized idle bit of port p. Whether the port passed or failed, halt_req[p] is lowered before the next port is visited, and it is zero when halt_done pulses.
- R6: Bit p of halt_fail belongs to port p. It keeps its value from halt_done until the next accepted halt_start, which clears all bits.
- R7: halt_done is high for exactly one cycle per accepted command, after the last port. A halt_start that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_start | input | 1 | One-cycle command that starts a halt pass over all ports |
| ms_tick | input | 1 | One-cycle pulse each millisecond, used for the timeout |
| halt_ack | input | NPORTS | Halt acknowledge from each port, asynchronous |
| port_idle | input | NPORTS | Idle indication from each port, asynchronous |
| halt_req | output | NPORTS | Halt request to each port |
| halt_done | output | 1 | One-cycle pulse when the pass is complete |
| halt_fail | output | NPORTS | Port failed to become idle, held until the next command |

## Verification
A wrong state or port index in the sequencer shows up in one of three ways. A request can appear on a port that was already idle, or out of index order. Two request bits can be high at once, which can be seen in the very cycle the wrong index is used. A stuck timeout counter shows up as a request that stays high past TIMEOUT_MS+2 ticks, which is seen within a few milliseconds. A wrong grading or a lost result shows up in halt_fail at the done pulse, and a failure bit that changes between passes shows up in whichever cycle it changes.

// File: rtl/axi_halt_seq.sv
module axi_halt_seq #(
  parameter int NPORTS     = 3,
  parameter int TIMEOUT_MS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_start,
  input  logic              ms_tick,
  input  logic [NPORTS-1:0] halt_ack,
  input  logic [NPORTS-1:0] port_idle,
  output logic [NPORTS-1:0] halt_req,
  output logic              halt_done,
  output logic [NPORTS-1:0] halt_fail
);
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int TW = $clog2(TIMEOUT_MS + 1);
  localparam logic [IW-1:0] LAST = IW'(NPORTS - 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_MS);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_WAIT, S_GRADE, S_NEXT} st_t;

  st_t             st;
  logic [IW-1:0]   idx;
  logic [TW-1:0]   tcnt;
  logic [NPORTS-1:0] ack_m, ack_s, idle_m, idle_s;
  logic            running;

  assign running = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_m <= '0; ack_s <= '0; idle_m <= '0; idle_s <= '0;
    end else begin
      ack_m <= halt_ack;  ack_s  <= ack_m;
      idle_m <= port_idle; idle_s <= idle_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      tcnt      <= '0;
      halt_req  <= '0;
      halt_done <= 1'b0;
      halt_fail <= '0;
    end else begin
      halt_done <= 1'b0;
      case (st)
        S_IDLE:
          if (halt_start) begin
            halt_fail <= '0;
            idx       <= '0;
            st        <= S_CHECK;
          end
        S_CHECK:
          if (idle_s[idx]) st <= S_NEXT;
          else begin
            halt_req[idx] <= 1'b1;
            tcnt          <= '0;
            st            <= S_WAIT;
          end
        S_WAIT:
          if (ack_s[idx] || tcnt == TLIM) st <= S_GRADE;
          else if (ms_tick) tcnt <= tcnt + 1'b1;
        S_GRADE: begin
          halt_fail[idx] <= ~idle_s[idx];
          halt_req[idx]  <= 1'b0;
          st             <= S_NEXT;
        end
        S_NEXT:
          if (idx == LAST) begin
            halt_done <= 1'b1;
            st        <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_CHECK;
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/axi_halt_seq_chk.sv
module axi_halt_seq_chk #(
  parameter int NPORTS     = 3,
  parameter int TIMEOUT_MS = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_start,
  input logic              ms_tick,
  input logic [NPORTS-1:0] halt_req,
  input logic              halt_done,
  input logic [NPORTS-1:0] halt_fail,
  input logic              running
);
  int unsigned req_ticks;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_ticks <= 0;
    else if (halt_req == '0) req_ticks <= 0;
    else if (ms_tick) req_ticks <= req_ticks + 1;

  AST_ONE_REQ:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(halt_req)); // R4
  AST_REQ_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) (halt_req != '0) |-> req_ticks <= TIMEOUT_MS + 2); // R3
  AST_DONE_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n) halt_done |-> halt_req == '0); // R5
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) halt_done |=> !halt_done); // R7
  AST_FAIL_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!running && !halt_start) |=> $stable(halt_fail)); // R6
endmodule

bind axi_halt_seq axi_halt_seq_chk #(.NPORTS(NPORTS), .TIMEOUT_MS(TIMEOUT_MS)) chk_i (
  .clk(clk), .rst_n(rst_n), .halt_start(halt_start), .ms_tick(ms_tick),
  .halt_req(halt_req), .halt_done(halt_done), .halt_fail(halt_fail), .running(running)
);

// File: tb/axi_halt_seq_tb.sv
module axi_halt_seq_tb_top;
  localparam int NP  = 3;
  localparam int LIM = 8;
  localparam int DLY = 5;

  typedef struct { logic [NP-1:0] fail; logic [NP-1:0] reqm; logic [NP-1:0] tmo; } exp_t;

  logic clk = 0, rst_n = 0, halt_start = 0, ms_tick = 0;
  logic [NP-1:0] halt_ack, port_idle, halt_req, halt_fail;
  logic halt_done;

  int tests = 0, fails = 0, dones = 0;
  int mode [NP];
  int hc [NP];
  int tk [NP];
  int tkf [NP];
  int rises [NP];
  int last_rise;
  bit order_bad;
  logic [NP-1:0] prev_req;
  logic prev_done;
  exp_t q[$];

  always #5 clk = ~clk;

  axi_halt_seq #(.NPORTS(NP), .TIMEOUT_MS(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_start(halt_start), .ms_tick(ms_tick),
    .halt_ack(halt_ack), .port_idle(port_idle), .halt_req(halt_req),
    .halt_done(halt_done), .halt_fail(halt_fail)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial forever begin
    repeat (3) @(negedge clk);
    ms_tick = 1;
    @(negedge clk);
    ms_tick = 0;
  end

  // bus model: 0 idle already, 1 ack+idle, 2 ack no idle, 3 silent, 4 idle late no ack
  initial forever begin
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      if (halt_req[p]) begin
        hc[p]++;
        if (hc[p] == DLY)
          case (mode[p])
            1: begin halt_ack[p] = 1; port_idle[p] = 1; end
            2: halt_ack[p] = 1;
            4: port_idle[p] = 1;
            default: ;
          endcase
      end
  end

  task automatic set_modes(input int m0, input int m1, input int m2);
    @(negedge clk);
    mode[0] = m0; mode[1] = m1; mode[2] = m2;
    for (int p = 0; p < NP; p++) begin
      hc[p] = 0; halt_ack[p] = 0; port_idle[p] = (mode[p] == 0);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start;
    @(negedge clk);
    halt_start = 1;
    @(negedge clk);
    halt_start = 0;
  endtask

  task automatic run_case(input int m0, input int m1, input int m2, input bit extra_start);
    exp_t e;
    int d0;
    int ms [NP];
    set_modes(m0, m1, m2);
    ms[0] = m0; ms[1] = m1; ms[2] = m2;
    for (int p = 0; p < NP; p++) begin
      e.fail[p] = (ms[p] == 2 || ms[p] == 3);
      e.reqm[p] = (ms[p] != 0);
      e.tmo[p]  = (ms[p] == 3 || ms[p] == 4);
    end
    q.push_back(e);
    d0 = dones;
    pulse_start();
    if (extra_start) begin
      repeat (10) @(negedge clk);
      pulse_start();
    end
    while (dones == d0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    prev_req = '0; prev_done = 0; last_rise = -1; order_bad = 0;
    for (int p = 0; p < NP; p++) begin tk[p] = 0; tkf[p] = 0; rises[p] = 0; end
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      chk(!(prev_done && halt_done), "R7", "done longer than one cycle", 1, 0);
      for (int p = 0; p < NP; p++) begin
        if (halt_req[p] && !prev_req[p]) begin
          rises[p]++;
          if (p < last_rise) order_bad = 1;
          last_rise = p;
          tk[p] = 0;
        end
        if (halt_req[p] && ms_tick) tk[p]++;
        if (!halt_req[p] && prev_req[p]) tkf[p] = tk[p];
      end
      if (halt_done) begin
        exp_t e;
        logic [NP-1:0] rm;
        dones++;
        if (q.size() == 0) chk(0, "R7", "done without command", 1, 0);
        else begin
          e = q.pop_front();
          for (int p = 0; p < NP; p++) rm[p] = (rises[p] != 0);
          chk(halt_fail == e.fail, "R5", "fail vector at done", halt_fail, e.fail);
          chk(rm == e.reqm, "R2", "ports requested", rm, e.reqm);
          chk(!order_bad, "R4", "request order", order_bad, 0);
          chk(halt_req == '0, "R5", "request low at done", halt_req, 0);
          for (int p = 0; p < NP; p++) begin
            chk(rises[p] <= 1, "R4", "request count per port", rises[p], 1);
            if (e.tmo[p])
              chk(tkf[p] >= LIM && tkf[p] <= LIM + 2, "R3", "ticks before timeout", tkf[p], LIM);
            else if (e.reqm[p])
              chk(tkf[p] < LIM, "R3", "ticks before ack", tkf[p], LIM - 1);
          end
        end
        for (int p = 0; p < NP; p++) begin rises[p] = 0; tk[p] = 0; tkf[p] = 0; end
        last_rise = -1; order_bad = 0;
      end
      prev_req = halt_req;
      prev_done = halt_done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d;
    for (int p = 0; p < NP; p++) begin mode[p] = 0; hc[p] = 0; end
    halt_ack = '0; port_idle = '0;
    repeat (4) @(negedge clk);
    chk(halt_req == '0 && !halt_done && halt_fail == '0, "R1", "outputs in reset", {halt_req, halt_done, halt_fail}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(halt_req == '0 && !halt_done && halt_fail == '0, "R1", "outputs after reset", {halt_req, halt_done, halt_fail}, 0);

    run_case(0, 0, 0, 0);   // R2 all idle
    run_case(1, 1, 1, 0);   // R4 all acked
    run_case(3, 1, 2, 0);   // R3 R5 timeout, ok, no idle
    repeat (20) @(negedge clk);
    chk(halt_fail == 3'b101, "R6", "fail held after done", halt_fail, 3'b101);

    set_modes(0, 4, 0);
    q.push_back('{fail: 3'b000, reqm: 3'b010, tmo: 3'b010});
    d = dones;
    pulse_start();
    @(negedge clk);
    chk(halt_fail == 3'b000, "R6", "fail cleared by command", halt_fail, 0);
    while (dones == d) @(negedge clk);
    repeat (3) @(negedge clk);

    d = dones;
    run_case(3, 0, 0, 1);   // R7 second command ignored
    repeat (60) @(negedge clk);
    chk(dones == d + 1, "R7", "done count with command while running", dones - d, 1);
    chk(q.size() == 0, "R7", "pending expected items", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule